// File: doc/BRIEF.md
# Timed Register-Stimulus Executor

This block executes one 52-bit stimulus instruction at a time against a bank of 32 single-bit output lines and 32 single-bit input lines. Each instruction pairs a register action with timing. The action can be a pulse on one output, a sample of one input, a scatter of an 8-bit value onto eight freely chosen outputs, or a gather of eight freely chosen inputs into a byte. The timing can be a hold of a given number of cycles, a delay of a given number of cycles, or a fixed one-second wait. The length of one second is set by the `SEC_CYCLES` parameter.

A test sequencer presents instructions through a valid/ready handshake. The executor keeps `instr_ready` low while a timed instruction is in progress. Read results come back on `rd_data` with a single-cycle `rd_valid` strobe. Opcodes that are not defined raise `bad_op` for one cycle and have no other effect.

Instruction layout:
- `[51:49]` opcode
- `[48:44]` primary select
- `[43:0]` count field, called AUX below

For the byte operations, value bit k is steered by the 5-bit select at `[9+5k +: 5]`. This places bit 7 at `[48:44]`, bit 1 at `[18:14]` and bit 0 at `[13:9]`. The value byte sits at `[7:0]`, and bit 8 is unused.

Top module: `stim_exec`

## Requirements
- R1: `instr_ready` is high exactly when no instruction is in progress. A word is taken when `instr_valid` and `instr_ready` are both high at a rising edge. While `instr_ready` is low, `instr_valid` and `instr_word` have no effect.
- R2: Opcode 000 pulses one output. From the cycle after acceptance, output number `[48:44]` is 1 and every other output is 0. This lasts for N = max(AUX,1) cycles.
- R3: Opcode 001 waits one second before pulsing. For `SEC_CYCLES` cycles after acceptance all outputs stay 0. The selected output is then 1 for N = max(AUX,1) cycles.
- R4: Opcode 100 reads one input after a delay. The block stays busy for N = max(AUX,1) cycles and samples input `[48:44]` in the last of those cycles. In the next cycle `rd_valid` is 1, `rd_data` equals {7'b0, sample}, and `instr_ready` is 1.
- R5: Opcode 011 is an immediate scatter write. For exactly one cycle after acceptance, the output selected by `[9+5k +: 5]` takes value bit k, for k = 0..7. Outputs not named stay 0, and word bit 8 is ignored.
- R6: In a scatter write, if two selects name the same output, the value bit with the higher index wins.
- R7: Opcode 111 is a delayed scatter write. All outputs stay 0 for `SEC_CYCLES` cycles after acceptance. The scatter pattern of R5 is then held for `SEC_CYCLES` cycles.
- R8: Opcode 101 is a gather read. The cycle after acceptance shows `rd_valid`=1 and `instr_ready`=1. Bit k of `rd_data` is the value, in the acceptance cycle, of the input named by `[9+5k +: 5]`. Word bits `[8:0]` are ignored.
- R9: Opcodes 010 and 110 raise `bad_op` for one cycle after acceptance. All outputs and `rd_valid` stay 0, and `instr_ready` stays 1.
- R10: An AUX of 0 behaves as a count of 1, both for hold lengths (R2, R3) and for read delays (R4).
- R11: A synchronous active-high `rst` clears all outputs, `rd_valid`, `rd_data` and `bad_op`, and sets `instr_ready`, even in the middle of an instruction.
- R12: When a hold ends, all outputs return to 0 in the same cycle that `instr_ready` rises. `rd_data` is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Executor idle and able to take a word |
| instr_word | input | 52 | Instruction: opcode, selects, count or value |
| reg_in | input | 32 | Input lines sampled by read operations |
| reg_out | output | 32 | Driven output register bank |
| rd_valid | output | 1 | One-cycle strobe marking a read result |
| rd_data | output | 8 | Read result (zero-extended for single reads) |
| bad_op | output | 1 | One-cycle flag for an undefined opcode |

## Verification
The embedded assertions watch a set of properties on every cycle:
- the outputs are all zero whenever the block is idle;
- a single pulse write lights exactly the addressed line in the next cycle;
- an immediate scatter write releases after one cycle;
- a gather read answers in the next cycle;
- `bad_op` only follows an undefined opcode and leaves everything else untouched;
- a delayed single read is always zero-extended.

Other behaviours can only be shown by the bench's scenarios, which compare against a cycle-by-cycle model:
- the exact lengths of the holds, the delays and the one-second wait;
- the instant at which a delayed read samples its input;
- which value bit wins when scatter selects are duplicated;
- that bit 8 and the low bits of a gather are ignored;
- that words offered while the block is busy are ignored;
- that a reset in the middle of an instruction aborts it.

// File: rtl/stim_exec.sv
module stim_exec #(
  parameter int SEC_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  output logic        instr_ready,
  input  logic [51:0] instr_word,
  input  logic [31:0] reg_in,
  output logic [31:0] reg_out,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        bad_op
);
  localparam int CW = 44;
  localparam logic [CW-1:0] SEC_CNT = (SEC_CYCLES < 1) ? CW'(1) : CW'(SEC_CYCLES);
  localparam logic [2:0] OP_PULSE = 3'b000, OP_DPULSE = 3'b001, OP_BWR = 3'b011,
                         OP_RD = 3'b100, OP_BRD = 3'b101, OP_DBWR = 3'b111;

  typedef enum logic [1:0] {IDLE, WAIT, HOLD} st_t;
  st_t st;
  logic [51:0] cur;
  logic [CW-1:0] cnt;

  wire acc = instr_valid && instr_ready;
  wire [2:0] in_op = instr_word[51:49];
  assign instr_ready = (st == IDLE);

  function automatic logic [31:0] onehot(input logic [51:0] w);
    return 32'd1 << w[48:44];
  endfunction

  function automatic logic [CW-1:0] atleast1(input logic [CW-1:0] a);
    return (a == '0) ? CW'(1) : a;
  endfunction

  function automatic logic [31:0] scatter(input logic [51:0] w);
    logic [31:0] p = '0;
    for (int k = 0; k < 8; k++) p[w[9+5*k +: 5]] = w[k];
    return p;
  endfunction

  function automatic logic [7:0] gather(input logic [51:0] w, input logic [31:0] lines);
    logic [7:0] g;
    for (int k = 0; k < 8; k++) g[k] = lines[w[9+5*k +: 5]];
    return g;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; cur <= '0; cnt <= '0;
      reg_out <= '0; rd_valid <= 1'b0; rd_data <= '0; bad_op <= 1'b0;
    end else begin
      rd_valid <= 1'b0; rd_data <= '0; bad_op <= 1'b0;
      case (st)
        IDLE: if (acc) begin
          cur <= instr_word;
          case (in_op)
            OP_PULSE: begin reg_out <= onehot(instr_word); cnt <= atleast1(instr_word[43:0]); st <= HOLD; end
            OP_BWR:   begin reg_out <= scatter(instr_word); cnt <= CW'(1); st <= HOLD; end
            OP_DPULSE, OP_DBWR: begin cnt <= SEC_CNT; st <= WAIT; end
            OP_RD:    begin cnt <= atleast1(instr_word[43:0]); st <= WAIT; end
            OP_BRD:   begin rd_valid <= 1'b1; rd_data <= gather(instr_word, reg_in); end
            default:  bad_op <= 1'b1;
          endcase
        end
        WAIT: if (cnt == CW'(1)) begin
          case (cur[51:49])
            OP_RD:     begin rd_valid <= 1'b1; rd_data <= {7'b0, reg_in[cur[48:44]]}; st <= IDLE; end
            OP_DPULSE: begin reg_out <= onehot(cur); cnt <= atleast1(cur[43:0]); st <= HOLD; end
            default:   begin reg_out <= scatter(cur); cnt <= SEC_CNT; st <= HOLD; end
          endcase
        end else cnt <= cnt - CW'(1);
        HOLD: if (cnt == CW'(1)) begin
          reg_out <= '0; st <= IDLE;
        end else cnt <= cnt - CW'(1);
        default: st <= IDLE;
      endcase
    end
  end

  // R12: an idle executor drives nothing
  a_r12_idle_clear: assert property (@(posedge clk) disable iff (rst)
    instr_ready |-> reg_out == '0);

  // R2: single pulse lights only the addressed line
  a_r2_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == OP_PULSE) |=> (reg_out == (32'd1 << $past(instr_word[48:44])) && !instr_ready));

  // R5: immediate scatter lasts one cycle
  a_r5_byte_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == OP_BWR) |=> ##1 (instr_ready && reg_out == '0));

  // R8: gather answers next cycle
  a_r8_gather_next: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == OP_BRD) |=> (rd_valid && instr_ready));

  // R9: illegal flag only after an undefined opcode
  a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> ($past(acc) && ($past(in_op) == 3'b010 || $past(in_op) == 3'b110)));

  // R9: undefined opcode leaves everything idle
  a_r9_no_effect: assert property (@(posedge clk) disable iff (rst)
    (acc && (in_op == 3'b010 || in_op == 3'b110)) |=> (instr_ready && reg_out == '0 && !rd_valid));

  // R4: delayed single read is zero-extended
  a_r4_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(acc)) |-> rd_data[7:1] == 7'b0);
endmodule

// File: tb/stim_exec_test.sv
`timescale 1ns/1ps
module stim_exec_test;
  localparam int SEC = 16;
  logic clk = 1'b0, rst = 1'b1, instr_valid = 1'b0;
  logic [51:0] instr_word = '0;
  logic [31:0] lines = '0;
  logic instr_ready, rd_valid, bad_op;
  logic [31:0] reg_out;
  logic [7:0] rd_data;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  stim_exec #(.SEC_CYCLES(SEC)) uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .reg_in(lines), .reg_out(reg_out),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_op(bad_op));

  typedef struct {
    bit rdy; logic [31:0] ro; bit rv; logic [7:0] rd; bit bad; int tag;
  } frm_t;
  frm_t q[$];

  function automatic frm_t fr(bit rdy, logic [31:0] ro, bit rv, logic [7:0] rd, bit bad, int tag);
    frm_t f;
    f.rdy = rdy; f.ro = ro; f.rv = rv; f.rd = rd; f.bad = bad; f.tag = tag;
    return f;
  endfunction

  function automatic logic [51:0] mk1(logic [2:0] op, logic [4:0] sel, logic [43:0] aux);
    return {op, sel, aux};
  endfunction

  function automatic logic [51:0] mkb(logic [2:0] op, logic [7:0][4:0] s, logic [7:0] v, logic [8:8] b8);
    logic [51:0] w = '0;
    w[51:49] = op;
    for (int k = 0; k < 8; k++) w[9+5*k +: 5] = s[k];
    w[8] = b8; w[7:0] = v;
    return w;
  endfunction

  // behavioural reference: expected frames for each cycle after acceptance
  task automatic plan(logic [51:0] w, int tag);
    logic [2:0] op = w[51:49];
    int sel = int'(w[48:44]);
    longint n = (w[43:0] == 0) ? 1 : longint'(w[43:0]);
    logic [31:0] pat = '0;
    logic [7:0] gat;
    for (int k = 0; k < 8; k++) begin
      int s = int'(w[9+5*k +: 5]);
      if (k == 0 || 1) pat[s] = w[k];
      gat[k] = lines[s];
    end
    case (op)
      3'b000: for (longint i = 0; i < n; i++) q.push_back(fr(0, 32'd1 << sel, 0, 0, 0, tag));
      3'b001: begin
        for (int i = 0; i < SEC; i++) q.push_back(fr(0, 0, 0, 0, 0, tag));
        for (longint i = 0; i < n; i++) q.push_back(fr(0, 32'd1 << sel, 0, 0, 0, tag));
      end
      3'b100: begin
        for (longint i = 0; i < n; i++) q.push_back(fr(0, 0, 0, 0, 0, tag));
        q.push_back(fr(1, 0, 1, {7'b0, lines[sel]}, 0, tag));
      end
      3'b011: q.push_back(fr(0, pat, 0, 0, 0, tag));
      3'b111: begin
        for (int i = 0; i < SEC; i++) q.push_back(fr(0, 0, 0, 0, 0, tag));
        for (int i = 0; i < SEC; i++) q.push_back(fr(0, pat, 0, 0, 0, tag));
      end
      3'b101: q.push_back(fr(1, 0, 1, gat, 0, tag));
      default: q.push_back(fr(1, 0, 0, 0, 1, tag));
    endcase
  endtask

  task automatic cyc();
    frm_t e;
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front() : fr(1, 0, 0, 0, 0, 1);
    vectors++;
    if (instr_ready !== e.rdy || reg_out !== e.ro || rd_valid !== e.rv ||
        rd_data !== e.rd || bad_op !== e.bad) begin
      miscompares++;
      $display("FAIL R%0d t=%0t: got rdy=%b out=%h rv=%b rd=%h bad=%b, expected rdy=%b out=%h rv=%b rd=%h bad=%b",
               e.tag, $time, instr_ready, reg_out, rd_valid, rd_data, bad_op,
               e.rdy, e.ro, e.rv, e.rd, e.bad);
    end
  endtask

  task automatic issue(logic [51:0] w, int tag);
    plan(w, tag);
    instr_valid = 1'b1; instr_word = w;
    cyc();
    instr_valid = 1'b0; instr_word = '0;
    while (q.size() != 0) cyc();
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R11: reset state
    for (int i = 0; i < 3; i++) begin q.push_back(fr(1, 0, 0, 0, 0, 11)); cyc(); end
    rst = 1'b0;
    cyc();

    issue(mk1(3'b000, 5'd5, 44'd3), 2);   // R2
    issue(mk1(3'b000, 5'd0, 44'd1), 2);   // R2 single cycle
    issue(mk1(3'b000, 5'd31, 44'd0), 10); // R10 zero hold
    issue(mk1(3'b001, 5'd9, 44'd2), 3);   // R3
    issue(mk1(3'b001, 5'd17, 44'd0), 10); // R10 with delayed pulse

    lines = 32'h0000_0080;
    issue(mk1(3'b100, 5'd7, 44'd4), 4);   // R4 reads 1
    lines = 32'hFFFF_FFFB;
    issue(mk1(3'b100, 5'd2, 44'd0), 10);  // R10 read delay 0 reads 0
    lines = 32'h0000_0004;
    issue(mk1(3'b100, 5'd2, 44'd1), 4);   // R4 reads 1

    // R5: distinct selects, bit 8 set and ignored
    issue(mkb(3'b011, {5'd30, 5'd1, 5'd12, 5'd3, 5'd25, 5'd6, 5'd19, 5'd8}, 8'hA5, 1'b1), 5);
    // R6: duplicates, higher bit wins
    issue(mkb(3'b011, {5'd4, 5'd2, 5'd2, 5'd2, 5'd10, 5'd11, 5'd10, 5'd4}, 8'h19, 1'b0), 6);
    // R7: delayed scatter held one second
    issue(mkb(3'b111, {5'd0, 5'd1, 5'd2, 5'd3, 5'd28, 5'd29, 5'd30, 5'd31}, 8'h3C, 1'b1), 7);

    // R8: gather with nonzero low bits ignored
    lines = 32'h8421_C3A5;
    issue(mkb(3'b101, {5'd31, 5'd26, 5'd16, 5'd0, 5'd5, 5'd2, 5'd1, 5'd7}, 8'hFF, 1'b1), 8);
    lines = 32'h1234_5678;
    issue(mkb(3'b101, {5'd3, 5'd3, 5'd4, 5'd9, 5'd20, 5'd28, 5'd13, 5'd6}, 8'h00, 1'b0), 8);

    issue(mk1(3'b010, 5'd3, 44'd5), 9);   // R9
    issue(mk1(3'b110, 5'd8, 44'd0), 9);   // R9

    // R1: words offered while busy are ignored
    plan(mk1(3'b000, 5'd12, 44'd5), 1);
    instr_valid = 1'b1; instr_word = mk1(3'b000, 5'd12, 44'd5);
    cyc();
    instr_word = mk1(3'b010, 5'd1, 44'd0);
    cyc(); cyc(); cyc();
    instr_valid = 1'b0; instr_word = '0;
    while (q.size() != 0) cyc();
    cyc();

    // R11: reset aborts an instruction in progress
    plan(mk1(3'b000, 5'd20, 44'd10), 11);
    instr_valid = 1'b1; instr_word = mk1(3'b000, 5'd20, 44'd10);
    cyc();
    instr_valid = 1'b0; instr_word = '0;
    cyc(); cyc();
    rst = 1'b1;
    q.delete();
    q.push_back(fr(1, 0, 0, 0, 0, 11));
    cyc();
    rst = 1'b0;
    cyc(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule